// File: doc/BRIEF.md
# Dual-Edge Multi-Lane Serial ADC Capture Controller

This block runs a simultaneous-sampling converter that sends its results over several serial data lanes. A one-cycle start request launches a conversion. The block raises the active-low convert strobe for a programmed number of cycles, then lowers it. The converter latches its samples on that falling edge. The block then waits out the conversion time and runs a gated serial clock at half the system rate. The serial clock idles low. Every system cycle in which it runs, it changes level.

The converter sends the serial clock and its enable back to the block, together with the data. The block captures one bit per lane on every level change of the returned clock while the returned enable is high. That gives two bits per serial clock period, and the capture works whatever the round-trip delay. Each lane carries several consecutive channels in turn. Once the final returned edge has been taken, every channel word is written at once and the done flag rises.

If the returned clock stops short, a bounded wait after the serial clock ends releases the block anyway. In that case the previous results are kept. Control is plain level and pulse signalling: start and done. The block has no streaming interface, so no back-pressure applies.

Top module: `ddr_adc_reader`

## Requirements
- R1: After reset, done is 1, cnv_n is 0, sclk is 0, sclk_en is 0 and every channel word is 0.
- R2: A start seen while done is 1 is accepted: done is 0 from the next cycle. A start seen while done is 0 has no effect on the conversion in progress or on its results.
- R3: After a start is accepted, cnv_n goes high on the next cycle and stays high for exactly T_CNVH cycles, then goes low. It is raised exactly once per conversion.
- R4: sclk first goes high exactly T_CONV cycles after cnv_n goes low.
- R5: sclk and sclk_en are both 0 whenever cnv_n is 1. sclk_en is high for W*CH/LANES consecutive cycles, during which sclk toggles every cycle starting from 1, which gives exactly W*CH/(2*LANES) rising edges per conversion. sclk ends low.
- R6: A bit is taken from every lane in each cycle where ret_en is 1 and ret_clk differs from its value in the previous cycle. That means both returned clock edges carry data.
- R7: Lane l carries channels l*CPL to l*CPL+CPL-1, where CPL = CH/LANES. They come in ascending channel order, each one MSB first. Channel c occupies words[c*W +: W].
- R8: The channel words are W-bit two's complement values. All of them update in the cycle done rises, and they hold while done stays 1.
- R9: For return delays of up to T_RTT cycles, done rises at most T_RTT+1 cycles after sclk_en falls, with all words from that conversion.
- R10: If the final returned edge has not arrived T_RTT+1 cycles after sclk_en falls, done rises anyway and the words keep their earlier values. sclk_en is never 1 while done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle conversion request |
| done | output | 1 | High when idle and results are valid |
| cnv_n | output | 1 | Active-low convert strobe to the converter |
| sclk | output | 1 | Serial clock to the converter |
| sclk_en | output | 1 | Serial clock enable, travels with sclk |
| ret_clk | input | 1 | Serial clock as returned from the converter side |
| ret_en | input | 1 | Returned serial clock enable |
| sdo | input | LANES | Serial data lanes |
| words | output | CH*W | Channel results, channel c at bits c*W +: W |

## Verification
The bench drives the design with a converter model that reflects the clock back through a delay line of selectable depth. It covers zero delay, the largest specified delay, and a delay beyond the limit that forces the timeout. A design that counted rising edges only would collect half the bits. A design that timed completion from the issued clock rather than the returned one would latch shifted words once the delay is nonzero. Data patterns include channel numbers, full-scale positive and negative values, alternating bits and random words, so a swapped lane-to-channel mapping or bit order shows up as a word mismatch. A second start pulsed mid-conversion would, if not ignored, show up as an extra convert pulse or corrupted words. After the timeout case, the previous words must still be present.

// File: rtl/ddr_adc_pkg.sv
package ddr_adc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CNVH,
    PH_CONV,
    PH_SCLK,
    PH_WAIT
  } phase_t;
endpackage

// File: rtl/ddr_adc_seq.sv
// Timing sequencer: convert strobe, conversion wait, serial clock burst,
// then a bounded wait for the returned clock to finish.
module ddr_adc_seq
  import ddr_adc_pkg::*;
#(
  parameter int T_CNVH = 4,
  parameter int T_CONV = 57,
  parameter int T_RTT  = 4,
  parameter int HALFS  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cap_last,
  output logic cnv_n,
  output logic sclk,
  output logic sclk_en,
  output logic done,
  output logic armed,
  output logic launch
);
  localparam int M1   = (T_CNVH > T_CONV) ? T_CNVH : T_CONV;
  localparam int M2   = (HALFS > T_RTT + 1) ? HALFS : T_RTT + 1;
  localparam int TMAX = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(TMAX + 1);

  phase_t        phase;
  logic [TW-1:0] timer;

  assign launch = (phase == PH_IDLE) && start;
  assign armed  = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      timer   <= '0;
      cnv_n   <= 1'b0;
      sclk    <= 1'b0;
      sclk_en <= 1'b0;
      done    <= 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_CNVH;
            cnv_n <= 1'b1;
            done  <= 1'b0;
            timer <= TW'(T_CNVH - 1);
          end
        end
        PH_CNVH: begin
          if (timer == '0) begin
            phase <= PH_CONV;
            cnv_n <= 1'b0;
            timer <= TW'(T_CONV - 1);
          end else begin
            timer <= timer - 1'b1;
          end
        end
        PH_CONV: begin
          if (timer == '0) begin
            phase   <= PH_SCLK;
            sclk_en <= 1'b1;
            sclk    <= 1'b1;
            timer   <= TW'(HALFS - 1);
          end else begin
            timer <= timer - 1'b1;
          end
        end
        PH_SCLK: begin
          if (timer != '0) begin
            sclk  <= ~sclk;
            timer <= timer - 1'b1;
          end else begin
            sclk_en <= 1'b0;
            sclk    <= 1'b0;
            if (cap_last) begin
              phase <= PH_IDLE;
              done  <= 1'b1;
            end else begin
              phase <= PH_WAIT;
            end
          end
        end
        PH_WAIT: begin
          if (cap_last || timer == TW'(T_RTT)) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
            timer <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ddr_adc_capture.sv
// Returned-clock edge detector and per-conversion bit counter.
module ddr_adc_capture #(
  parameter int BITS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic launch,
  input  logic ret_clk,
  input  logic ret_en,
  output logic shift,
  output logic last
);
  localparam int CW = $clog2(BITS + 1);

  logic          ret_prev;
  logic [CW-1:0] count;

  assign shift = armed && ret_en && (ret_clk != ret_prev) && (count != CW'(BITS));
  assign last  = shift && (count == CW'(BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_prev <= 1'b0;
      count    <= '0;
    end else begin
      ret_prev <= ret_clk;
      if (launch)     count <= '0;
      else if (shift) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/ddr_adc_lane.sv
// One serial lane: MSB-first shift register with its next value exposed.
module ddr_adc_lane #(
  parameter int BITS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift,
  input  logic            sdo,
  output logic [BITS-1:0] nxt
);
  logic [BITS-1:0] sr;

  assign nxt = {sr[BITS-2:0], sdo};

  always_ff @(posedge clk) begin
    if (!rst_n)     sr <= '0;
    else if (shift) sr <= nxt;
  end
endmodule

// File: rtl/ddr_adc_reader.sv
module ddr_adc_reader #(
  parameter int W      = 16,
  parameter int CH     = 8,
  parameter int LANES  = 4,
  parameter int T_CNVH = 4,
  parameter int T_CONV = 57,
  parameter int T_RTT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              cnv_n,
  output logic              sclk,
  output logic              sclk_en,
  input  logic              ret_clk,
  input  logic              ret_en,
  input  logic [LANES-1:0]  sdo,
  output logic [CH*W-1:0]   words
);
  localparam int CPL  = CH / LANES;
  localparam int BITS = W * CPL;

  logic armed, launch, shift, last;
  logic [BITS-1:0] lane_nxt [LANES];
  logic [CH*W-1:0] words_nxt;

  ddr_adc_seq #(
    .T_CNVH(T_CNVH), .T_CONV(T_CONV), .T_RTT(T_RTT), .HALFS(BITS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cap_last(last),
    .cnv_n(cnv_n), .sclk(sclk), .sclk_en(sclk_en), .done(done),
    .armed(armed), .launch(launch)
  );

  ddr_adc_capture #(.BITS(BITS)) u_cap (
    .clk(clk), .rst_n(rst_n), .armed(armed), .launch(launch),
    .ret_clk(ret_clk), .ret_en(ret_en), .shift(shift), .last(last)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ddr_adc_lane #(.BITS(BITS)) u_lane (
      .clk(clk), .rst_n(rst_n), .shift(shift), .sdo(sdo[l]), .nxt(lane_nxt[l])
    );
    for (genvar j = 0; j < CPL; j++) begin : g_chan
      // first channel of the lane arrived first, so it sits highest
      assign words_nxt[(l*CPL+j)*W +: W] = lane_nxt[l][BITS-1-j*W -: W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    words <= '0;
    else if (last) words <= words_nxt;
  end
endmodule

// File: rtl/ddr_adc_reader_chk.sv
module ddr_adc_reader_chk #(
  parameter int W      = 16,
  parameter int CH     = 8,
  parameter int LANES  = 4,
  parameter int T_CNVH = 4,
  parameter int T_CONV = 57,
  parameter int T_RTT  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input logic             cnv_n,
  input logic             sclk,
  input logic             sclk_en,
  input logic             ret_clk,
  input logic             ret_en,
  input logic [LANES-1:0] sdo,
  input logic [CH*W-1:0]  words
);
  logic [15:0] hi_cnt, lo_cnt, tail;
  logic        seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
      tail   <= '0;
      seen   <= 1'b0;
    end else begin
      hi_cnt <= cnv_n ? hi_cnt + 1'b1 : '0;
      if (done || cnv_n)  lo_cnt <= '0;
      else if (!sclk_en)  lo_cnt <= lo_cnt + 1'b1;
      if (done)           seen <= 1'b0;
      else if (sclk_en)   seen <= 1'b1;
      if (done || sclk_en) tail <= '0;
      else if (seen)       tail <= tail + 1'b1;
    end
  end

  a_r2_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && done) |=> !done);
  a_r3_cnvh_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_n) |-> (hi_cnt == 16'(T_CNVH)));
  a_r4_conv_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_en) |-> (lo_cnt == 16'(T_CONV)));
  a_r5_sclk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_n |-> (!sclk && !sclk_en));
  a_r8_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> $stable(words));
  a_r9_done_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !done && !sclk_en) |-> (tail <= 16'(T_RTT)));
  a_r10_en_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_en |-> !done);
endmodule

bind ddr_adc_reader ddr_adc_reader_chk #(
  .W(W), .CH(CH), .LANES(LANES), .T_CNVH(T_CNVH), .T_CONV(T_CONV), .T_RTT(T_RTT)
) u_chk (.*);

// File: tb/ddr_adc_reader_test.sv
`timescale 1ns/1ps
module ddr_adc_reader_test;
  localparam int W = 16, CH = 8, LANES = 4, T_CNVH = 4, T_CONV = 57, T_RTT = 4;
  localparam int CPL = CH / LANES, BITS = W * CPL, NPER = BITS / 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic done, cnv_n, sclk, sclk_en, ret_clk, ret_en;
  logic [LANES-1:0] sdo;
  logic [CH*W-1:0] words;

  always #5 clk = ~clk;

  ddr_adc_reader #(.W(W), .CH(CH), .LANES(LANES), .T_CNVH(T_CNVH),
                   .T_CONV(T_CONV), .T_RTT(T_RTT)) uut (.*);

  // converter model with a selectable return delay
  int unsigned rtt = 0;
  logic [7:0] pclk = '0, pen = '0;
  logic [W-1:0] chdata [CH];
  logic [BITS-1:0] mlane [LANES];
  int mcnt = BITS;
  logic mprev = 1'b0, cprev = 1'b0;

  always @(posedge clk) begin
    pclk  <= {pclk[6:0], sclk};
    pen   <= {pen[6:0], sclk_en};
    cprev <= cnv_n;
    mprev <= ret_clk;
    if (cprev && !cnv_n) begin
      for (int l = 0; l < LANES; l++)
        for (int j = 0; j < CPL; j++)
          mlane[l][BITS-1-j*W -: W] <= chdata[l*CPL+j];
      mcnt <= 0;
    end else if (ret_en && ret_clk != mprev) begin
      mcnt <= mcnt + 1;
    end
  end

  always_comb begin
    ret_clk = (rtt == 0) ? sclk : pclk[rtt-1];
    ret_en  = (rtt == 0) ? sclk_en : pen[rtt-1];
    for (int l = 0; l < LANES; l++)
      sdo[l] = (mcnt < BITS) ? mlane[l][BITS-1-mcnt] : 1'b0;
  end

  // monitor sampled away from the active edge
  int cyc = 0, sclk_rises = 0, cnv_pulses = 0;
  int cnv_rise_cyc = 0, cnv_fall_cyc = 0, first_sclk_cyc = 0;
  logic got_rise = 1'b0, ps = 1'b0, pc = 1'b0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    ps  <= sclk;
    pc  <= cnv_n;
    if (sclk && !ps) begin
      sclk_rises <= sclk_rises + 1;
      if (!got_rise) begin first_sclk_cyc <= cyc; got_rise <= 1'b1; end
    end
    if (cnv_n && !pc) begin cnv_pulses <= cnv_pulses + 1; cnv_rise_cyc <= cyc; end
    if (!cnv_n && pc) begin cnv_fall_cyc <= cyc; got_rise <= 1'b0; end
  end

  int n_chk = 0, n_bad = 0;
  logic [W-1:0] held [CH];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected below 150000", cyc);
    finish_run();
  end

  task automatic run_one(input int unsigned d, input bit poke, input bit expect_ok);
    int r0, c0, waited;
    rtt = d;
    @(negedge clk);
    r0 = sclk_rises; c0 = cnv_pulses;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R2 done drops", 64'(done), 64'd0);
    if (poke) begin
      repeat (10) @(negedge clk);
      start = 1'b1;               // R2: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 2000) begin @(negedge clk); waited++; end
    check(done == 1'b1, "R9 done returns", 64'(done), 64'd1);
    check(cnv_pulses - c0 == 1, "R3 one convert pulse", 64'(cnv_pulses - c0), 64'd1);
    check(cnv_fall_cyc - cnv_rise_cyc == T_CNVH, "R3 convert width",
          64'(cnv_fall_cyc - cnv_rise_cyc), 64'(T_CNVH));
    check(first_sclk_cyc - cnv_fall_cyc == T_CONV, "R4 conversion gap",
          64'(first_sclk_cyc - cnv_fall_cyc), 64'(T_CONV));
    check(sclk_rises - r0 == NPER, "R5 sclk periods", 64'(sclk_rises - r0), 64'(NPER));
    for (int c = 0; c < CH; c++) begin
      if (expect_ok) held[c] = chdata[c];
      check(words[c*W +: W] == held[c], expect_ok ? "R6 R7 R8 channel word" : "R10 words kept",
            64'(words[c*W +: W]), 64'(held[c]));
    end
    for (int c = 0; c < CH; c++) chdata[c] = W'($urandom);
    repeat (6) @(negedge clk);
    for (int c = 0; c < CH; c++)
      check(words[c*W +: W] == held[c], "R8 hold while idle", 64'(words[c*W +: W]), 64'(held[c]));
  endtask

  initial begin
    void'($urandom(32'h5eed_0a7c));
    for (int c = 0; c < CH; c++) begin chdata[c] = '0; held[c] = '0; end
    for (int l = 0; l < LANES; l++) mlane[l] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b1, "R1 done", 64'(done), 64'd1);
    check(cnv_n == 1'b0, "R1 cnv_n", 64'(cnv_n), 64'd0);
    check(sclk == 1'b0, "R1 sclk", 64'(sclk), 64'd0);
    check(sclk_en == 1'b0, "R1 sclk_en", 64'(sclk_en), 64'd0);
    check(words == '0, "R1 words", 64'(words), 64'd0);

    for (int c = 0; c < CH; c++) chdata[c] = W'(c);
    run_one(0, 1'b0, 1'b1);
    for (int c = 0; c < CH; c++) chdata[c] = 16'h7fff;
    run_one(T_RTT, 1'b0, 1'b1);
    for (int c = 0; c < CH; c++) chdata[c] = 16'h8000;
    run_one(2, 1'b1, 1'b1);
    for (int c = 0; c < CH; c++) chdata[c] = c[0] ? 16'h5555 : 16'haaaa;
    run_one(1, 1'b0, 1'b1);
    run_one(T_RTT + 3, 1'b0, 1'b0);   // R10 timeout keeps earlier words
    for (int k = 0; k < 10; k++) begin
      for (int c = 0; c < CH; c++) chdata[c] = W'($urandom);
      run_one($urandom_range(0, T_RTT), 1'($urandom), 1'b1);
    end
    finish_run();
  end
endmodule